// File: doc/BRIEF.md
# Dual-Domain Bridge Reset Coordinator

This block sits beside an asynchronous bridge whose two halves run on unrelated clocks. It takes one active-low system reset that may arrive at any time. From it the block makes a reset for each half and a ready flag for each half. Reset reaches both halves at once and needs no clock. The release of each half is synchronized to that half's own clock. No single released reset is ever shared between the two clocks.

Each half also learns, through its own synchronizer, that the other half has left reset. The ready flag of a half goes high only when both of these hold:
- its own reset is released;
- it has seen the other half's release.

A half that leaves reset early therefore holds its bridge pointers in their empty state and keeps its VALIDs low until the whole bridge is quiescent. If the system reset asserts again at any point, both halves return to reset and the whole release sequence starts over.

Top module: `bridge_rst_coord`

## Requirements
- R1: While `rst_ni` is low, `rst_a_no` and `rst_b_no` are low. They go low within the same time step that `rst_ni` falls, even when neither clock is running.
- R2: While `rst_ni` is low, `ready_a_o` and `ready_b_o` are low. They drop as soon as `rst_ni` falls, with no clock edge needed.
- R3: With default parameters (two stages), `rst_a_no` rises on the 2nd rising edge of `clk_a_i` after `rst_ni` rises. `rst_b_no` rises on the 2nd rising edge of `clk_b_i` after `rst_ni` rises.
- R4: The release of one domain does not depend on the other clock. `rst_a_no` is released even while `clk_b_i` is stopped.
- R5: `ready_a_o` is never high while `rst_b_no` is low. `ready_b_o` is never high while `rst_a_no` is low.
- R6: A ready output rises only on an edge of its own clock at which its own reset was already released. It stays low while the peer clock is stopped and the peer is still in reset.
- R7: Once both domain resets are released, each ready output is high by the 4th rising edge of its own clock. That edge is counted from the point where both resets were seen released.
- R8: If `rst_ni` asserts again at any point of the release sequence, both domains restart from reset. Each release is then counted afresh from the new release of `rst_ni`.
- R9: Once a ready output is high, it stays high until `rst_ni` next asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Clock of bridge half A |
| clk_b_i | input | 1 | Clock of bridge half B, unrelated to A |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| rst_a_no | output | 1 | Active-low reset for half A; asserts asynchronously, releases on clk_a_i |
| rst_b_no | output | 1 | Active-low reset for half B; asserts asynchronously, releases on clk_b_i |
| ready_a_o | output | 1 | Half A may start issuing transfers |
| ready_b_o | output | 1 | Half B may start issuing transfers |

## Verification
The hardest state to reach is a half bridge: one domain is out of reset and the other is still held in it. With both clocks running, this window lasts only a few cycles. The stimulus therefore stops `clk_b_i` before releasing the system reset, lets half A run for many cycles, and then restarts B. It also re-asserts reset at random points in the release sequence and releases it at random phases of both clocks. These releases are kept clear of clock edges, so that the bench's edge counts are exact.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned NUM_DOM    = 2;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum int unsigned {
    DOM_A = 0,
    DOM_B = 1
  } dom_e;
endpackage

// File: rtl/brc_rst_sync.sv
// Async assert, release shifted in on clk_i.
module brc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q << 1) | STAGES'(1);
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/brc_flag_sync.sv
// Level synchronizer, cleared asynchronously by the system reset.
module brc_flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic flag_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q << 1) | STAGES'(flag_i);
  end

  assign flag_o = q[STAGES-1];
endmodule

// File: rtl/brc_domain.sv
module brc_domain #(
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned PEER_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic peer_rel_i,  // peer's released reset, foreign clock
  output logic rst_no,
  output logic ready_o
);
  logic rel;
  logic peer_up;
  logic ready_q;

  brc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rel)
  );

  // Cleared by the system reset, so a new assertion restarts the handshake.
  brc_flag_sync #(.STAGES(PEER_STAGES)) u_peer_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (peer_rel_i),
    .flag_o (peer_up)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= rel & peer_up;
  end

  assign rst_no  = rel;
  assign ready_o = ready_q;
endmodule

// File: rtl/bridge_rst_coord.sv
module bridge_rst_coord
  import brc_pkg::*;
#(
  parameter int unsigned RST_STAGES  = DEF_STAGES,
  parameter int unsigned PEER_STAGES = DEF_STAGES
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  output logic rst_a_no,
  output logic rst_b_no,
  output logic ready_a_o,
  output logic ready_b_o
);
  logic [NUM_DOM-1:0] clk_v;
  logic [NUM_DOM-1:0] rel_v;
  logic [NUM_DOM-1:0] rdy_v;

  assign clk_v[DOM_A] = clk_a_i;
  assign clk_v[DOM_B] = clk_b_i;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    brc_domain #(
      .RST_STAGES  (RST_STAGES),
      .PEER_STAGES (PEER_STAGES)
    ) u_dom (
      .clk_i      (clk_v[d]),
      .rst_ni     (rst_ni),
      .peer_rel_i (rel_v[NUM_DOM-1-d]),
      .rst_no     (rel_v[d]),
      .ready_o    (rdy_v[d])
    );
  end

  assign rst_a_no  = rel_v[DOM_A];
  assign rst_b_no  = rel_v[DOM_B];
  assign ready_a_o = rdy_v[DOM_A];
  assign ready_b_o = rdy_v[DOM_B];
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
  input logic clk_a_i,
  input logic clk_b_i,
  input logic rst_ni,
  input logic rst_a_no,
  input logic rst_b_no,
  input logic ready_a_o,
  input logic ready_b_o
);
  // R1 R2: reset holds domain outputs quiet
  a_r1_quiet_a: assert property (@(posedge clk_a_i)
    !rst_ni |-> (!rst_a_no && !ready_a_o));
  a_r1_quiet_b: assert property (@(posedge clk_b_i)
    !rst_ni |-> (!rst_b_no && !ready_b_o));

  // R5: no ready while peer in reset
  a_r5_peer_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ready_a_o |-> rst_b_no);
  a_r5_peer_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    ready_b_o |-> rst_a_no);

  // R6: ready rises only after own release
  a_r6_own_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $rose(ready_a_o) |-> $past(rst_a_no));
  a_r6_own_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $rose(ready_b_o) |-> $past(rst_b_no));
endmodule

bind bridge_rst_coord brc_checker u_chk (.*);

// File: tb/bridge_rst_coord_tb.sv
`timescale 1ns/1ps
module bridge_rst_coord_tb;
  localparam int unsigned STG = 2;
  localparam real HA = 4.0;    // 125 MHz
  localparam real HB = 2.925;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic en_a = 1'b1, en_b = 1'b1;
  logic rst_a_n, rst_b_n, rdy_a, rdy_b;
  int checks = 0, errors = 0;
  int ca = 0, cb = 0;
  int both_a = 0, both_b = 0;
  logic prev_ra = 1'b0, prev_rb = 1'b0, prev_sa = 1'b0, prev_sb = 1'b0;
  logic rst_hit_a = 1'b0, rst_hit_b = 1'b0;
  bit done = 1'b0;

  bridge_rst_coord u_dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .rst_a_no(rst_a_n), .rst_b_no(rst_b_n),
    .ready_a_o(rdy_a), .ready_b_o(rdy_b)
  );

  always #(HA) clk_a = en_a ? ~clk_a : clk_a;
  always #(HB) clk_b = en_b ? ~clk_b : clk_b;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_a or negedge rst_n)
    if (!rst_n) ca <= 0; else if (ca < 50) ca <= ca + 1;
  always @(posedge clk_b or negedge rst_n)
    if (!rst_n) cb <= 0; else if (cb < 50) cb <= cb + 1;
  always @(negedge rst_n) begin rst_hit_a = 1'b1; rst_hit_b = 1'b1; end

  // Domain A monitor
  always @(posedge clk_a) begin
    #1;
    if (!done) begin
      chk(rst_a_n == (rst_n && ca >= STG), "R3/R8 rst_a_no", rst_a_n, rst_n && ca >= STG);
      chk(!(rdy_a && !rst_b_n), "R5 ready_a_o vs rst_b_no", rdy_a, 0);
      both_a = (rst_a_n && rst_b_n) ? both_a + 1 : 0;
      if (both_a <= 1) chk(!(rdy_a && !prev_sa), "R6 ready_a_o early", rdy_a, 0);
      if (both_a >= 4) chk(rdy_a, "R7 ready_a_o late", rdy_a, 1);
      if (prev_ra && !rst_hit_a) chk(rdy_a, "R9 ready_a_o hold", rdy_a, 1);
      prev_ra = rdy_a; prev_sa = rst_a_n; rst_hit_a = 1'b0;
    end
  end

  // Domain B monitor
  always @(posedge clk_b) begin
    #1;
    if (!done) begin
      chk(rst_b_n == (rst_n && cb >= STG), "R3/R8 rst_b_no", rst_b_n, rst_n && cb >= STG);
      chk(!(rdy_b && !rst_a_n), "R5 ready_b_o vs rst_a_no", rdy_b, 0);
      both_b = (rst_a_n && rst_b_n) ? both_b + 1 : 0;
      if (both_b <= 1) chk(!(rdy_b && !prev_sb), "R6 ready_b_o early", rdy_b, 0);
      if (both_b >= 4) chk(rdy_b, "R7 ready_b_o late", rdy_b, 1);
      if (prev_rb && !rst_hit_b) chk(rdy_b, "R9 ready_b_o hold", rdy_b, 1);
      prev_rb = rdy_b; prev_sb = rst_b_n; rst_hit_b = 1'b0;
    end
  end

  function automatic bit near_edge(input real t, input real h);
    real r;
    r = t - $floor(t / h) * h;
    return (r < 0.05) || (r > h - 0.05);
  endfunction

  // Release at a random phase clear of both clock grids
  task automatic release_rst();
    #(($urandom % 4000) * 0.001);
    while (near_edge($realtime, HA) || near_edge($realtime, HB)) #0.137;
    rst_n = 1'b1;
  endtask

  task automatic assert_rst();
    rst_n = 1'b0;
    #0.2;
    chk(!rst_a_n && !rst_b_n, "R1 domain resets low", {rst_a_n, rst_b_n}, 0);
    chk(!rdy_a && !rdy_b, "R2 ready low", {rdy_a, rdy_b}, 0);
  endtask

  initial begin
    #(200_000 * 8.0);
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk(!rst_a_n && !rst_b_n && !rdy_a && !rdy_b, "R1 R2 reset state",
        {rst_a_n, rst_b_n, rdy_a, rdy_b}, 0);

    // Random releases, some re-asserted mid-sequence (R8)
    for (int i = 0; i < 24; i++) begin
      release_rst();
      repeat ($urandom % 30) @(posedge clk_a);
      #(($urandom % 3000) * 0.001);
      assert_rst();
      #(($urandom % 20) + 1);
    end

    // Peer clock stopped: A releases alone (R4, R6)
    @(negedge clk_b); en_b = 1'b0;
    release_rst();
    repeat (20) @(posedge clk_a);
    #2;
    chk(rst_a_n, "R4 rst_a_no with clk_b stopped", rst_a_n, 1);
    chk(!rst_b_n, "R4 rst_b_no held", rst_b_n, 0);
    chk(!rdy_a, "R6 ready_a_o waits for peer", rdy_a, 0);
    en_b = 1'b1;
    repeat (20) @(posedge clk_a);
    #2;
    chk(rdy_a && rdy_b, "R7 both ready", {rdy_a, rdy_b}, 3);

    // Both clocks stopped: reset asserts with no clock (R1, R2)
    @(negedge clk_a); en_a = 1'b0;
    @(negedge clk_b); en_b = 1'b0;
    #3;
    assert_rst();
    release_rst();
    #30;
    chk(!rst_a_n && !rst_b_n && !rdy_a && !rdy_b, "R3 no release without clocks",
        {rst_a_n, rst_b_n, rdy_a, rdy_b}, 0);
    en_a = 1'b1; en_b = 1'b1;
    repeat (20) @(posedge clk_a);
    #2;
    chk(rdy_a && rdy_b, "R7 ready after clocks resume", {rdy_a, rdy_b}, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule